// File: doc/BRIEF.md
# Two-Slot Edge Capture Unit

This unit watches a timer pin that has been set up as an input. It timestamps selected transitions of that pin against a free-running counter. The pin is first brought into the local clock domain. Its level is then compared with the level from the previous cycle to find rising and falling transitions. A two-bit mode field chooses which transitions count.

Each transition that counts copies the counter value into one of two holding registers: the first one, then the second. Once both registers hold a value, the unit ignores further transitions. It stays in that state until software clears the capture status, or until capture is switched from off to on again.

A select bit decides whether the one-cycle event strobe to the interrupt logic fires with the first snapshot or with the second. That lets software measure a single time stamp or a full period.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers read zero, the event strobe is low and the next qualifying transition fills the first register.
- R2: The mode field encodes 0 = off (no capture), 1 = rising transitions only, 2 = falling transitions only, 3 = both directions.
- R3: Nothing is captured while the direction input is low (pin used as output). Both registers keep their value and the strobe stays low.
- R4: A qualifying pin change becomes visible in a capture register right after the third rising clock edge after the change. The register holds the counter value present at that third edge. The first qualifying transition fills the first register and the second fills the second.
- R5: With both registers filled, further transitions change neither register and raise no event.
- R6: With the select bit at 0 the event strobe fires on the first capture. With the select bit at 1 it fires on the second capture. The strobe is high for exactly one cycle, in the cycle where the register that triggered it shows its new value.
- R7: A one-cycle clear strobe returns the sequence to its start, so the next qualifying transition fills the first register again. Register contents are kept until they are overwritten.
- R8: Changing the mode from 0 to any non-zero value returns the sequence to its start. A change between two non-zero modes does not.
- R9: If a clear or a restart coincides with the cycle in which a transition would be captured, the clear wins: that transition is dropped and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Running counter value to snapshot |
| pin_i | input | 1 | Asynchronous timer pin level |
| pin_is_input_i | input | 1 | 1 = pin configured as input, capture allowed |
| edge_mode_i | input | 2 | Capture mode (see R2) |
| fire_on_second_i | input | 1 | 0 = event on first capture, 1 = on second |
| clear_i | input | 1 | One-cycle strobe from the status-clear write |
| cap_first_o | output | CNT_W | First capture register |
| cap_second_o | output | CNT_W | Second capture register |
| event_o | output | 1 | One-cycle capture event to interrupt logic |

## Verification
The clear strobe and a capture can fall in the same cycle. This happens when software clears the status just as a synchronised pin transition reaches the sequencer. The bench provokes the collision by raising the clear strobe in the exact cycle before the capturing clock edge. It judges the result by R9: the registers stay unchanged, no event appears, and a later transition lands in the first register. The same collision is repeated with the mode going from off to on instead of a clear, which must behave identically.

// File: rtl/ecap_pkg.sv
// Package: shared types for the edge capture unit.
// Assumes: the mode field is two bits wide and encoded as below.
package ecap_pkg;
    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

    // Sequence position: number of slots already filled.
    typedef enum logic [1:0] {
        SEQ_EMPTY = 2'd0,
        SEQ_ONE   = 2'd1,
        SEQ_FULL  = 2'd2
    } seq_pos_e;
endpackage

// File: rtl/ecap_pin_sync.sv
// Module: ecap_pin_sync
// Brings the asynchronous pin into the clock domain through STAGES flops
// and keeps the previous synchronised level for transition detection.
// Assumes: STAGES >= 2; all flops reset to a low level.
module ecap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    // Remember the last synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = prev_q;

    // R4: the delayed copy follows the synchronised level one cycle later
    prev_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_o == $past(level_o));
endmodule

// File: rtl/ecap_edge_qual.sv
// Module: ecap_edge_qual
// Decides, from the synchronised level and its previous value, whether a
// transition of the selected kind is present this cycle.
// Assumes: inputs are already in the clock domain.
module ecap_edge_qual
    import ecap_pkg::*;
(
    input  logic      level_i,
    input  logic      prev_i,
    input  cap_mode_e mode_i,
    input  logic      dir_in_i,
    output logic      hit_o
);
    logic rise, fall;

    // Classify the transition and filter it through mode and direction.
    always_comb begin
        rise = level_i & ~prev_i;
        fall = ~level_i & prev_i;
        unique case (mode_i)
            CAP_RISE: hit_o = rise;
            CAP_FALL: hit_o = fall;
            CAP_BOTH: hit_o = rise | fall;
            default:  hit_o = 1'b0;
        endcase
        if (!dir_in_i) hit_o = 1'b0;
    end
endmodule

// File: rtl/ecap_seq.sv
// Module: ecap_seq
// Two-slot capture sequencer: stores the counter on each hit into slot one
// then slot two, raises a one-cycle event at the selected slot, ignores hits
// when full, and restarts on clear or on a mode change from off to on.
// Assumes: hit_i is a single-cycle qualified transition.
module ecap_seq
    import ecap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] count_i,
    input  cap_mode_e        mode_i,
    input  logic             fire_on_second_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cap_first_o,
    output logic [CNT_W-1:0] cap_second_o,
    output logic             event_o
);
    seq_pos_e         pos_q;
    logic             was_off_q;
    logic             restart;
    logic [CNT_W-1:0] slot1_q, slot2_q;
    logic             event_q;
    seq_pos_e         fire_pos;

    assign restart  = clear_i | (was_off_q & (mode_i != CAP_OFF));
    assign fire_pos = fire_on_second_i ? SEQ_ONE : SEQ_EMPTY;

    // Track whether the mode was off last cycle, for re-arming.
    always_ff @(posedge clk) begin
        if (!rst_n) was_off_q <= 1'b1;
        else        was_off_q <= (mode_i == CAP_OFF);
    end

    // Advance the sequence, load the slots and form the event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= SEQ_EMPTY;
            slot1_q <= '0;
            slot2_q <= '0;
            event_q <= 1'b0;
        end else begin
            event_q <= 1'b0;
            if (restart) begin
                pos_q <= SEQ_EMPTY;
            end else if (hit_i && pos_q != SEQ_FULL) begin
                if (pos_q == SEQ_EMPTY) begin
                    slot1_q <= count_i;
                    pos_q   <= SEQ_ONE;
                end else begin
                    slot2_q <= count_i;
                    pos_q   <= SEQ_FULL;
                end
                event_q <= (pos_q == fire_pos);
            end
        end
    end

    assign cap_first_o  = slot1_q;
    assign cap_second_o = slot2_q;
    assign event_o      = event_q;

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pos_q == SEQ_EMPTY) && !event_o && $stable(slot1_q) && $stable(slot2_q));
    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == SEQ_FULL) |=> $stable(slot1_q) && $stable(slot2_q) && !event_o);
    // R4
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !restart && pos_q == SEQ_EMPTY) |=> slot1_q == $past(count_i));
    // R6
    event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);
endmodule

// File: rtl/edge_capture_unit.sv
// Module: edge_capture_unit (top)
// Input-capture front end of a timer pin: synchroniser, transition
// qualifier and two-slot capture sequencer.
// Assumes: count_i is a free-running counter in the clk domain.
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic             pin_is_input_i,
    input  logic [1:0]       edge_mode_i,
    input  logic             fire_on_second_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cap_first_o,
    output logic [CNT_W-1:0] cap_second_o,
    output logic             event_o
);
    logic      lvl, prev, hit;
    cap_mode_e mode;

    assign mode = cap_mode_e'(edge_mode_i);

    ecap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(lvl), .prev_o(prev)
    );

    ecap_edge_qual u_qual (
        .level_i(lvl), .prev_i(prev), .mode_i(mode),
        .dir_in_i(pin_is_input_i), .hit_o(hit)
    );

    ecap_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .count_i(count_i),
        .mode_i(mode), .fire_on_second_i(fire_on_second_i),
        .clear_i(clear_i), .cap_first_o(cap_first_o),
        .cap_second_o(cap_second_o), .event_o(event_o)
    );

    // R3
    dir_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input_i |=> $stable(cap_first_o) && $stable(cap_second_o) && !event_o);
    // R2
    mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i == 2'd0) |=> $stable(cap_first_o) && $stable(cap_second_o) && !event_o);
endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] count_r = '0;
    logic         pin_r = 1'b0;
    logic         dir_r = 1'b1;
    logic [1:0]   mode_r = 2'd0;
    logic         sel_r = 1'b0;
    logic         clr_r = 1'b0;
    logic [W-1:0] c1, c2;
    logic         ev;

    int n_chk = 0, n_fail = 0;
    // bench model
    int           m_pos = 0;
    logic [W-1:0] m1 = '0, m2 = '0;

    always #2.5 clk = ~clk;

    edge_capture_unit uut (
        .clk(clk), .rst_n(rst_n), .count_i(count_r), .pin_i(pin_r),
        .pin_is_input_i(dir_r), .edge_mode_i(mode_r),
        .fire_on_second_i(sel_r), .clear_i(clr_r),
        .cap_first_o(c1), .cap_second_o(c2), .event_o(ev)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R2: does a change old->new qualify under the mode
    function automatic bit qualifies(input logic [1:0] md, input logic o, input logic n);
        case (md)
            2'd1: return !o && n;
            2'd2: return o && !n;
            2'd3: return o != n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_regs(input string req);
        check(c1 == m1, req, c1, m1);
        check(c2 == m2, req, c2, m2);
    endtask

    // Drive a pin level; sample after the third rising edge (R4, R6).
    task automatic pin_to(input logic lvl, input string req);
        bit hit;
        bit exp_ev;
        hit = dir_r && qualifies(mode_r, pin_r, lvl) && m_pos < 2;
        count_r = $urandom;
        pin_r = lvl;
        exp_ev = 1'b0;
        if (hit) begin
            if (m_pos == 0) m1 = count_r; else m2 = count_r;
            exp_ev = (m_pos == int'(sel_r));
            m_pos++;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_regs(req);
        check(ev == exp_ev, {req, " event"}, W'(ev), W'(exp_ev));
        @(negedge clk);
        check(ev == 1'b0, "R6 pulse width", W'(ev), '0);
    endtask

    task automatic set_mode(input logic [1:0] md);
        if (mode_r == 2'd0 && md != 2'd0) m_pos = 0;
        mode_r = md;
        @(negedge clk);
    endtask

    task automatic do_clear();
        clr_r = 1'b1;
        @(negedge clk);
        clr_r = 1'b0;
        m_pos = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(c1 == '0, "R1 first reg", c1, '0);
        check(c2 == '0, "R1 second reg", c2, '0);
        check(ev == 1'b0, "R1 event", W'(ev), '0);

        // R2 mode off: nothing captured
        pin_to(1'b1, "R2 off");
        pin_to(1'b0, "R2 off");
        // R2 rising only, select first (R6)
        set_mode(2'd1); sel_r = 1'b0;
        pin_to(1'b1, "R4 rise first");
        pin_to(1'b0, "R2 fall ignored in rise mode");
        pin_to(1'b1, "R4 rise second");
        // R5 full
        pin_to(1'b0, "R5 full");
        pin_to(1'b1, "R5 full");
        // R8 non-zero change does not rearm
        set_mode(2'd3);
        pin_to(1'b0, "R8 no rearm");
        // R7 clear restarts, select second
        do_clear(); sel_r = 1'b1;
        pin_to(1'b1, "R7 after clear first");
        pin_to(1'b0, "R6 fire on second");
        // R8 off then on rearms; falling mode
        set_mode(2'd0); set_mode(2'd2); sel_r = 1'b0;
        pin_to(1'b1, "R2 rise ignored in fall mode");
        pin_to(1'b0, "R8 rearm first");
        // R3 direction output
        dir_r = 1'b0; @(negedge clk);
        pin_to(1'b1, "R3 output dir");
        pin_to(1'b0, "R3 output dir");
        dir_r = 1'b1; @(negedge clk);

        // R9 clear collides with capture
        set_mode(2'd3);
        count_r = $urandom;
        pin_r = ~pin_r;
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr_r = 1'b1;
        @(negedge clk);
        clr_r = 1'b0;
        m_pos = 0;
        check_regs("R9 clear wins");
        check(ev == 1'b0, "R9 no event", W'(ev), '0);
        pin_to(~pin_r, "R9 next lands in first");

        // R9 rearm collides with capture
        set_mode(2'd0);
        count_r = $urandom;
        pin_r = ~pin_r;
        repeat (2) @(posedge clk);
        @(negedge clk);
        mode_r = 2'd3;
        @(negedge clk);
        m_pos = 0;
        check_regs("R9 rearm wins");
        check(ev == 1'b0, "R9 rearm no event", W'(ev), '0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) do_clear();
            else if (op == 1) set_mode(2'($urandom_range(0, 3)));
            else if (op == 2) begin dir_r = 1'($urandom); @(negedge clk); end
            else if (op == 3) begin sel_r = 1'($urandom); @(negedge clk); end
            else pin_to(~pin_r, "R4 random");
        end
        report();
    end
endmodule